// File: doc/BRIEF.md
# Fixed-Latency Dual-Requester Line Memory

This block is a synchronous storage array that serves two requesters: an instruction-fetch port and a data port. A third, maintenance side port writes single words. Storage is arranged as lines of four 32-bit words. Every normal access is a word read, a word write, a line read or a line write, and it takes a fixed, parameterised number of cycles. The requester keeps presenting the same request each cycle. The block answers WAIT on each presentation except the last one, which it answers OK. The access is performed on that OK presentation.

Only one of the two requesters makes progress at a time. Once a port has been granted, it keeps ownership until its access completes, until it withdraws its request, or until it replaces the request with another one, which restarts the count. The other port is held at WAIT and earns no credit toward its own latency while it waits. The side port is meant for loading and patching the storage. Its writes bypass both the arbitration and the latency, and they complete in the cycle they are presented.

Top module: `dual_port_line_mem`

## Requirements
- R1: With latency parameter DELAY, the first DELAY consecutive presentations of an unchanged request from the owning port are answered WAIT. WAIT means the port's request is high and its ok output is 0. The next presentation is answered with ok = 1, and the access is performed then.
- R2: With DELAY = 0, a request from a port that meets no owner completes with ok = 1 on its first presentation.
- R3: Storage is not changed before an access is answered OK, and a withdrawn request leaves storage unchanged. The rdata output of a port is all zeros on every cycle in which that port is not answered OK.
- R4: The op code is a 2-bit field: 0 reads a word, 1 writes a word, 2 reads a line, 3 writes a line. An address indexes words: bits [AW-1:2] select the line and bits [1:0] select the word. A line access uses the whole line for any of the line's four word addresses. Word i of a line occupies bits [32i+31:32i]. A word read returns the addressed word in rdata bits [31:0], with the upper bits zero. A word write takes its value from wdata bits [31:0].
- R5: A word write changes only the addressed word. The other three words of the line keep their values.
- R6: While one requester owns an access, the other requester is answered WAIT and makes no progress. This includes the cycle in which the owner completes. The waiting requester's count begins on the following cycle, so it completes 2·DELAY+1 cycles after the owner started.
- R7: A side-port write is answered s_ok = 1 in the cycle it is presented, whatever the value of DELAY and whether or not an access is in progress.
- R8: After reset every word of storage reads as zero.
- R9: If the owning port changes its op code or its address before completion, the old access is dropped. The changed presentation counts as the first presentation of the new request.
- R10: When both ports present requests in the same cycle with no owner, the data port is granted first.
- R11: If a side-port write and a port write complete in the same cycle on the same word, the side-port value is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| d_req | input | 1 | Data port request valid |
| d_op | input | 2 | Data port op code |
| d_addr | input | AW | Data port word address |
| d_wdata | input | 128 | Data port write data (word in bits [31:0]) |
| d_ok | output | 1 | Data port answered OK |
| d_rdata | output | 128 | Data port read data, valid with d_ok |
| f_req | input | 1 | Fetch port request valid |
| f_op | input | 2 | Fetch port op code |
| f_addr | input | AW | Fetch port word address |
| f_wdata | input | 128 | Fetch port write data |
| f_ok | output | 1 | Fetch port answered OK |
| f_rdata | output | 128 | Fetch port read data, valid with f_ok |
| s_we | input | 1 | Side-port word write strobe |
| s_addr | input | AW | Side-port word address |
| s_wdata | input | 32 | Side-port word value |
| s_ok | output | 1 | Side-port write answered OK |

## Verification
Two functions of this block can fall in the same cycle:
- A port can complete while the other port is waiting. The bench provokes this by starting both ports together, and also by starting them one cycle apart. It then checks that the waiting port completes exactly 2·DELAY+1 cycles after the first port started, and never on the first port's completion cycle.
- A side-port write can land on the very cycle a data line write completes, on a word of that same line. The stored result is checked by a later line read, which must show the data line with that one word replaced by the side-port value.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
  localparam int WORD_W = 32;
  localparam int WPL    = 4;
  localparam int LINE_W = WORD_W * WPL;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [WORD_W-1:0] word_t;

  // op[0] = write, op[1] = whole line
  typedef enum logic [1:0] {
    OP_RD_WORD = 2'd0,
    OP_WR_WORD = 2'd1,
    OP_RD_LINE = 2'd2,
    OP_WR_LINE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_DATA  = 2'd1,
    OWN_FETCH = 2'd2
  } own_e;

  function automatic logic [WPL-1:0] write_mask(logic [1:0] op, logic [1:0] sel);
    if (!op[0])     return '0;
    else if (op[1]) return '1;
    else            return WPL'(1) << sel;
  endfunction

  function automatic line_t spread_word(word_t w);
    return {WPL{w}};
  endfunction

  function automatic line_t merge_words(line_t old, line_t nw, logic [WPL-1:0] mask);
    line_t r;
    for (int i = 0; i < WPL; i++)
      r[i*WORD_W +: WORD_W] = mask[i] ? nw[i*WORD_W +: WORD_W] : old[i*WORD_W +: WORD_W];
    return r;
  endfunction

  function automatic line_t read_view(line_t l, logic is_line, logic [1:0] sel);
    if (is_line) return l;
    return {{(LINE_W-WORD_W){1'b0}}, l[sel*WORD_W +: WORD_W]};
  endfunction
endpackage

// File: rtl/dlm_arbiter.sv
module dlm_arbiter
  import dlm_pkg::*;
#(
  parameter int DELAY = 3,
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_req,
  input  logic [KEY_W-1:0] d_key,
  input  logic             f_req,
  input  logic [KEY_W-1:0] f_key,
  output logic             d_done,
  output logic             f_done,
  output own_e             owner
);
  localparam int CW = $clog2(DELAY + 2);
  localparam logic [CW-1:0] LAST = CW'(DELAY);

  own_e             own_q, own_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [KEY_W-1:0] key_q, key_d;

  function automatic logic at_limit(logic [CW-1:0] c);
    return c == LAST;
  endfunction

  always_comb begin
    own_d  = own_q;
    cnt_d  = cnt_q;
    key_d  = key_q;
    d_done = 1'b0;
    f_done = 1'b0;
    unique case (own_q)
      OWN_NONE: begin
        if (d_req) begin
          if (DELAY == 0) d_done = 1'b1;
          else begin
            own_d = OWN_DATA;
            cnt_d = CW'(1);
            key_d = d_key;
          end
        end else if (f_req) begin
          if (DELAY == 0) f_done = 1'b1;
          else begin
            own_d = OWN_FETCH;
            cnt_d = CW'(1);
            key_d = f_key;
          end
        end
      end
      OWN_DATA: begin
        if (!d_req) own_d = OWN_NONE;
        else if (d_key != key_q) begin
          cnt_d = CW'(1);
          key_d = d_key;
        end else if (at_limit(cnt_q)) begin
          d_done = 1'b1;
          own_d  = OWN_NONE;
        end else cnt_d = cnt_q + CW'(1);
      end
      OWN_FETCH: begin
        if (!f_req) own_d = OWN_NONE;
        else if (f_key != key_q) begin
          cnt_d = CW'(1);
          key_d = f_key;
        end else if (at_limit(cnt_q)) begin
          f_done = 1'b1;
          own_d  = OWN_NONE;
        end else cnt_d = cnt_q + CW'(1);
      end
      default: own_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q <= OWN_NONE;
      cnt_q <= '0;
      key_q <= '0;
    end else begin
      own_q <= own_d;
      cnt_q <= cnt_d;
      key_q <= key_d;
    end
  end

  assign owner = own_q;
endmodule

// File: rtl/dlm_store.sv
module dlm_store
  import dlm_pkg::*;
#(
  parameter int LINES = 16,
  localparam int LW = $clog2(LINES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [LW-1:0]  wr_line,
  input  logic [WPL-1:0] wr_mask,
  input  line_t          wr_data,
  input  logic           sd_we,
  input  logic [LW-1:0]  sd_line,
  input  logic [1:0]     sd_word,
  input  word_t          sd_data,
  input  logic [LW-1:0]  ra_line,
  output line_t          ra_data,
  input  logic [LW-1:0]  rb_line,
  output line_t          rb_data
);
  line_t line_q [LINES];
  logic [WPL-1:0] sd_mask;

  assign sd_mask = WPL'(1) << sd_word;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_t nxt;
    always_comb begin
      nxt = line_q[g];
      if (wr_line == LW'(g)) nxt = merge_words(nxt, wr_data, wr_mask);
      // side port applied last so it wins a same-word collision
      if (sd_we && sd_line == LW'(g)) nxt = merge_words(nxt, spread_word(sd_data), sd_mask);
    end
    always_ff @(posedge clk) begin
      if (!rst_n) line_q[g] <= '0;
      else        line_q[g] <= nxt;
    end
  end

  assign ra_data = line_q[ra_line];
  assign rb_data = line_q[rb_line];
endmodule

// File: rtl/dual_port_line_mem.sv
module dual_port_line_mem
  import dlm_pkg::*;
#(
  parameter int LINES = 16,
  parameter int DELAY = 3,
  localparam int AW = $clog2(LINES) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_req,
  input  logic [1:0]        d_op,
  input  logic [AW-1:0]     d_addr,
  input  logic [LINE_W-1:0] d_wdata,
  output logic              d_ok,
  output logic [LINE_W-1:0] d_rdata,
  input  logic              f_req,
  input  logic [1:0]        f_op,
  input  logic [AW-1:0]     f_addr,
  input  logic [LINE_W-1:0] f_wdata,
  output logic              f_ok,
  output logic [LINE_W-1:0] f_rdata,
  input  logic              s_we,
  input  logic [AW-1:0]     s_addr,
  input  logic [WORD_W-1:0] s_wdata,
  output logic              s_ok
);
  localparam int LW = AW - 2;

  logic d_done, f_done;
  own_e owner;

  dlm_arbiter #(.DELAY(DELAY), .KEY_W(AW + 2)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .d_req (d_req),
    .d_key ({d_op, d_addr}),
    .f_req (f_req),
    .f_key ({f_op, f_addr}),
    .d_done(d_done),
    .f_done(f_done),
    .owner (owner)
  );

  // completing access, named for the checker
  logic          port_fire;
  logic [1:0]    fire_op;
  logic [AW-1:0] fire_addr;
  line_t         fire_wdata;
  logic [WPL-1:0] wr_mask;
  line_t         wr_data;

  assign port_fire  = d_done | f_done;
  assign fire_op    = d_done ? d_op    : f_op;
  assign fire_addr  = d_done ? d_addr  : f_addr;
  assign fire_wdata = d_done ? d_wdata : f_wdata;
  assign wr_mask    = port_fire ? write_mask(fire_op, fire_addr[1:0]) : '0;
  assign wr_data    = fire_op[1] ? fire_wdata : spread_word(fire_wdata[WORD_W-1:0]);

  line_t d_line, f_line;

  dlm_store #(.LINES(LINES)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_line(fire_addr[AW-1:2]),
    .wr_mask(wr_mask),
    .wr_data(wr_data),
    .sd_we  (s_we),
    .sd_line(s_addr[AW-1:2]),
    .sd_word(s_addr[1:0]),
    .sd_data(s_wdata),
    .ra_line(d_addr[AW-1:2]),
    .ra_data(d_line),
    .rb_line(f_addr[AW-1:2]),
    .rb_data(f_line)
  );

  assign d_ok    = d_done;
  assign f_ok    = f_done;
  assign s_ok    = s_we;
  assign d_rdata = (d_done && !d_op[0]) ? read_view(d_line, d_op[1], d_addr[1:0]) : '0;
  assign f_rdata = (f_done && !f_op[0]) ? read_view(f_line, f_op[1], f_addr[1:0]) : '0;

  logic [LW-1:0] unused_lw;
  assign unused_lw = '0;
endmodule

// File: rtl/dlm_chk.sv
module dlm_chk
  import dlm_pkg::*;
#(
  parameter int DELAY = 3
) (
  input logic clk,
  input logic rst_n,
  input logic d_req,
  input logic f_req,
  input logic d_ok,
  input logic f_ok,
  input own_e owner
);
  // R6
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n) !(d_ok && f_ok));
  // R1
  d_ok_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n) d_ok |-> d_req);
  // R1
  f_ok_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n) f_ok |-> f_req);
  // R1
  d_no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (DELAY > 0 && d_ok) |=> !d_ok);
  // R1
  f_no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (DELAY > 0 && f_ok) |=> !f_ok);
  // R6
  data_owner_blocks_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_DATA) |-> !f_ok);
  // R6
  fetch_owner_blocks_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_FETCH) |-> !d_ok);
endmodule

bind dual_port_line_mem dlm_chk #(.DELAY(DELAY)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .d_req(d_req),
  .f_req(f_req),
  .d_ok (d_ok),
  .f_ok (f_ok),
  .owner(owner)
);

// File: tb/test_dual_port_line_mem.sv
`timescale 1ns/1ps
module test_dual_port_line_mem;
  localparam int LINES = 16;
  localparam int DELAY = 3;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic d_req = 0, f_req = 0, s_we = 0;
  logic [1:0] d_op = 0, f_op = 0;
  logic [AW-1:0] d_addr = 0, f_addr = 0, s_addr = 0;
  logic [127:0] d_wdata = 0, f_wdata = 0;
  logic [31:0] s_wdata = 0;
  logic d_ok, f_ok, s_ok;
  logic [127:0] d_rdata, f_rdata;

  dual_port_line_mem #(.LINES(LINES), .DELAY(DELAY)) i_dual_port_line_mem (
    .clk(clk), .rst_n(rst_n),
    .d_req(d_req), .d_op(d_op), .d_addr(d_addr), .d_wdata(d_wdata), .d_ok(d_ok), .d_rdata(d_rdata),
    .f_req(f_req), .f_op(f_op), .f_addr(f_addr), .f_wdata(f_wdata), .f_ok(f_ok), .f_rdata(f_rdata),
    .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_ok(s_ok));

  // zero-latency instance
  logic z_d_req = 0, z_f_req = 0, z_s_we = 0;
  logic [1:0] z_d_op = 0, z_f_op = 0;
  logic [AW-1:0] z_d_addr = 0, z_f_addr = 0, z_s_addr = 0;
  logic [127:0] z_d_wdata = 0, z_f_wdata = 0;
  logic [31:0] z_s_wdata = 0;
  logic z_d_ok, z_f_ok, z_s_ok;
  logic [127:0] z_d_rdata, z_f_rdata;

  dual_port_line_mem #(.LINES(LINES), .DELAY(0)) i_dual_port_line_mem_z (
    .clk(clk), .rst_n(rst_n),
    .d_req(z_d_req), .d_op(z_d_op), .d_addr(z_d_addr), .d_wdata(z_d_wdata), .d_ok(z_d_ok), .d_rdata(z_d_rdata),
    .f_req(z_f_req), .f_op(z_f_op), .f_addr(z_f_addr), .f_wdata(z_f_wdata), .f_ok(z_f_ok), .f_rdata(z_f_rdata),
    .s_we(z_s_we), .s_addr(z_s_addr), .s_wdata(z_s_wdata), .s_ok(z_s_ok));

  int nchk = 0, nerr = 0;
  logic sd_ok, sf_ok, ss_ok, szd_ok, szf_ok;
  logic [127:0] sd_rd, sf_rd, szd_rd, szf_rd;
  logic [127:0] ref_mem [LINES];

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // sample mid-cycle, then move on to the next falling edge
  task automatic tick;
    #1;
    sd_ok = d_ok; sd_rd = d_rdata; sf_ok = f_ok; sf_rd = f_rdata; ss_ok = s_ok;
    szd_ok = z_d_ok; szd_rd = z_d_rdata; szf_ok = z_f_ok; szf_rd = z_f_rdata;
    @(negedge clk);
  endtask

  task automatic ref_write(logic [1:0] op, logic [AW-1:0] a, logic [127:0] wd);
    if (op == 2'd3) ref_mem[a[AW-1:2]] = wd;
    else if (op == 2'd1) ref_mem[a[AW-1:2]][a[1:0]*32 +: 32] = wd[31:0];
  endtask

  function automatic logic [127:0] ref_read(logic [1:0] op, logic [AW-1:0] a);
    if (op == 2'd2) return ref_mem[a[AW-1:2]];
    return {96'd0, ref_mem[a[AW-1:2]][a[1:0]*32 +: 32]};
  endfunction

  // one data-port access with the WAIT count and read data checked
  task automatic d_access(string req, logic [1:0] op, logic [AW-1:0] a, logic [127:0] wd);
    int waits = 0;
    logic [127:0] rd = '0;
    bit seen = 0;
    logic [127:0] exp_rd;
    exp_rd = op[0] ? 128'd0 : ref_read(op, a);
    d_req = 1; d_op = op; d_addr = a; d_wdata = wd;
    for (int c = 0; c < 20 && !seen; c++) begin
      tick;
      if (sd_ok) begin seen = 1; rd = sd_rd; end
      else begin
        waits++;
        if (sd_rd !== '0) chk("R3", "rdata during WAIT", sd_rd, '0);
      end
    end
    d_req = 0;
    chk(req, "WAIT count", 128'(waits), 128'(DELAY));
    chk(req, "read data", rd, exp_rd);
    ref_write(op, a, wd);
  endtask

  task automatic t_reset;
    d_access("R8", 2'd2, 6'd0, '0);
    d_access("R8", 2'd2, 6'd63, '0);
  endtask

  task automatic t_word_write;
    d_access("R4", 2'd3, 6'd10, {32'hA3A3A3A3, 32'hA2A2A2A2, 32'hA1A1A1A1, 32'hA0A0A0A0});
    d_access("R1", 2'd1, 6'd9, {96'd0, 32'h5555AAAA});
    d_access("R5", 2'd2, 6'd11, '0);
    d_access("R4", 2'd0, 6'd9, '0);
    d_access("R4", 2'd0, 6'd8, '0);
  endtask

  task automatic t_abandon;
    d_req = 1; d_op = 2'd1; d_addr = 6'd4; d_wdata = {96'd0, 32'hDEADBEEF};
    for (int c = 0; c < DELAY; c++) begin
      tick;
      chk("R3", "withdrawn access stays WAIT", 128'(sd_ok), 128'd0);
    end
    d_req = 0;
    tick;
    d_access("R3", 2'd2, 6'd5, '0);
  endtask

  task automatic contend(string req, int ds, int fs,
                         logic [1:0] dop, logic [AW-1:0] da, logic [127:0] dwd,
                         logic [1:0] fop, logic [AW-1:0] fa, logic [127:0] fwd,
                         output int dc, output int fc,
                         output logic [127:0] rdd, output logic [127:0] rdf);
    dc = -1; fc = -1; rdd = '0; rdf = '0;
    d_op = dop; d_addr = da; d_wdata = dwd;
    f_op = fop; f_addr = fa; f_wdata = fwd;
    for (int c = 0; c < 30 && (dc < 0 || fc < 0); c++) begin
      if (c == ds) d_req = 1;
      if (c == fs) f_req = 1;
      tick;
      if (sd_ok && dc < 0) begin dc = c; rdd = sd_rd; d_req = 0; end
      if (sf_ok && fc < 0) begin fc = c; rdf = sf_rd; f_req = 0; end
    end
    d_req = 0; f_req = 0;
  endtask

  task automatic t_conflict_same_start;
    int dc, fc;
    logic [127:0] rdd, rdf;
    contend("R10", 0, 0, 2'd1, 6'd20, {96'd0, 32'h0BADF00D}, 2'd2, 6'd21, '0, dc, fc, rdd, rdf);
    ref_write(2'd1, 6'd20, {96'd0, 32'h0BADF00D});
    chk("R10", "data finishes first", 128'(dc), 128'(DELAY));
    chk("R6", "fetch waits through data completion", 128'(fc), 128'(2*DELAY+1));
    chk("R6", "fetch line sees data write", rdf, ref_mem[5]);
  endtask

  task automatic t_conflict_fetch_first;
    int dc, fc;
    logic [127:0] rdd, rdf;
    contend("R6", 1, 0, 2'd0, 6'd20, '0, 2'd3, 6'd28, {4{32'h77778888}}, dc, fc, rdd, rdf);
    ref_write(2'd3, 6'd28, {4{32'h77778888}});
    chk("R6", "fetch owner finishes", 128'(fc), 128'(DELAY));
    chk("R6", "late data gains no credit", 128'(dc), 128'(2*DELAY+1));
    chk("R6", "data word read", rdd, {96'd0, 32'h0BADF00D});
  endtask

  task automatic t_restart;
    int okc = -1;
    logic [127:0] rd = '0;
    d_req = 1; d_op = 2'd0; d_addr = 6'd8;
    for (int c = 0; c < 20 && okc < 0; c++) begin
      if (c == 2) d_addr = 6'd9;
      tick;
      if (sd_ok) begin okc = c; rd = sd_rd; end
    end
    d_req = 0;
    chk("R9", "restart completion cycle", 128'(okc), 128'(2 + DELAY));
    chk("R9", "new address read", rd, ref_read(2'd0, 6'd9));
  endtask

  task automatic t_side_during_access;
    int okc = -1;
    logic [127:0] rd = '0;
    d_req = 1; d_op = 2'd2; d_addr = 6'd12;
    for (int c = 0; c < 20 && okc < 0; c++) begin
      if (c == 1) begin s_we = 1; s_addr = 6'd13; s_wdata = 32'hC0FFEE11; end
      else s_we = 0;
      tick;
      if (c == 1) chk("R7", "side ok same cycle", 128'(ss_ok), 128'd1);
      if (sd_ok) begin okc = c; rd = sd_rd; end
    end
    s_we = 0; d_req = 0;
    ref_mem[3][32 +: 32] = 32'hC0FFEE11;
    chk("R7", "data latency unchanged by side write", 128'(okc), 128'(DELAY));
    chk("R7", "side word visible in line", rd, ref_mem[3]);
  endtask

  task automatic t_collide;
    logic [127:0] line_v;
    int okc = -1;
    line_v = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111};
    d_req = 1; d_op = 2'd3; d_addr = 6'd21; d_wdata = line_v;
    for (int c = 0; c < 20 && okc < 0; c++) begin
      if (c == DELAY) begin s_we = 1; s_addr = 6'd22; s_wdata = 32'h99999999; end
      else s_we = 0;
      tick;
      if (sd_ok) okc = c;
    end
    s_we = 0; d_req = 0;
    chk("R11", "port write completes with side write", 128'(okc), 128'(DELAY));
    ref_mem[5] = line_v;
    ref_mem[5][64 +: 32] = 32'h99999999;
    d_access("R11", 2'd2, 6'd20, '0);
  endtask

  task automatic t_zero;
    z_d_req = 1; z_d_op = 2'd3; z_d_addr = 6'd6; z_d_wdata = {4{32'h12345678}};
    tick;
    chk("R2", "zero-latency write ok", 128'(szd_ok), 128'd1);
    z_d_op = 2'd2; z_d_addr = 6'd5;
    tick;
    chk("R2", "zero-latency read ok", 128'(szd_ok), 128'd1);
    chk("R2", "zero-latency read data", szd_rd, {4{32'h12345678}});
    z_d_op = 2'd0; z_d_addr = 6'd7;
    z_f_req = 1; z_f_op = 2'd0; z_f_addr = 6'd4;
    tick;
    chk("R10", "zero-latency data wins", 128'(szd_ok), 128'd1);
    chk("R10", "zero-latency fetch waits", 128'(szf_ok), 128'd0);
    z_d_req = 0;
    tick;
    chk("R2", "zero-latency fetch next cycle", 128'(szf_ok), 128'd1);
    chk("R2", "zero-latency fetch word", szf_rd, {96'd0, 32'h12345678});
    z_f_req = 0;
    tick;
  endtask

  bit finished = 0;
  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) ref_mem[i] = '0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_n = 1;
    tick;
    chk("R8", "idle after reset", {125'd0, sd_ok, sf_ok, ss_ok}, '0);
    t_reset;
    t_word_write;
    t_abandon;
    t_conflict_same_start;
    t_conflict_fetch_first;
    t_restart;
    t_side_during_access;
    t_collide;
    t_zero;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule